// File: doc/BRIEF.md
# Work Distributor with In-Order Result Reassembly

This block takes a single stream of work commands and spreads them across a set of parallel worker engines. It offers two dispatch policies, chosen at run time by a policy input. Round-robin visits the workers in turn. Least-busy picks the worker that holds the fewest unfinished commands. The distributor counts each worker's unfinished commands itself: a counter goes up when a command is handed to that worker and down when the worker returns a result.

Every accepted command is tagged with a 4-bit sequence number that travels with it to the worker. Workers may finish in any order. Each result is written into a reorder slot chosen by its sequence number, and results leave the block strictly in the order their commands arrived. The block holds at most 16 commands between acceptance and release. The input, each worker request port, each worker response port and the ordered output all use valid/ready handshakes.

Top module: `work_distributor`

## Requirements
- R1: After reset, `out_valid` is 0, no worker request is valid while `in_valid` is 0, `in_ready` is 1 when the workers are ready, the round-robin pointer is at worker 0, every occupancy count is 0, and the next sequence number is 0.
- R2: With `policy_sel` = 0 (round-robin), successive accepted commands go to workers 0, 1, 2, 3, 0, … starting from the current pointer position.
- R3: With `policy_sel` = 1 (least-busy), a command goes to the worker with the fewest outstanding commands. Ties go to the lowest worker index. A worker's count rises on dispatch to it and falls when it returns a result.
- R4: Accepted commands receive sequence numbers 0, 1, 2, … that wrap modulo 16. The number is presented on the chosen worker's `wk_req_id` slice.
- R5: Results are released on `out_id`/`out_data` strictly in sequence-number order. `out_valid` stays 0 while the result for the oldest unreleased number has not returned, even if later results have returned.
- R6: When 16 commands are held (accepted but not released), `in_ready` is 0 and no worker request is valid. Releasing the oldest result frees a slot again.
- R7: When the selected worker's `wk_req_ready` is 0, `in_ready` is 0. Only the selected worker's request is valid, and the command is not given to another worker.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_id` and `out_data` hold their values.
- R9: Dispatches made under least-busy do not move the round-robin pointer. A later switch back to round-robin resumes from where the pointer stood.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| policy_sel | input | 1 | 0 = round-robin, 1 = least-busy |
| in_valid | input | 1 | Command offered |
| in_ready | output | 1 | Command accepted this cycle when high with `in_valid` |
| in_data | input | DATA_W | Command payload |
| wk_req_valid | output | NUM_WK | Per-worker request valid |
| wk_req_ready | input | NUM_WK | Per-worker request ready |
| wk_req_data | output | NUM_WK*DATA_W | Per-worker command payload (slice per worker) |
| wk_req_id | output | NUM_WK*ID_W | Per-worker sequence number (slice per worker) |
| wk_rsp_valid | input | NUM_WK | Per-worker result valid |
| wk_rsp_ready | output | NUM_WK | Per-worker result ready (always high) |
| wk_rsp_data | input | NUM_WK*RES_W | Per-worker result payload |
| wk_rsp_id | input | NUM_WK*ID_W | Sequence number of the returned result |
| out_valid | output | 1 | Ordered result available |
| out_ready | input | 1 | Downstream accepts the ordered result |
| out_id | output | ID_W | Sequence number of the released result |
| out_data | output | RES_W | Released result payload |

## Verification
The assertions assume the workers behave: each worker returns only sequence numbers it was handed, returns each one exactly once, and never returns a result it has not yet received. A slot being written is therefore always empty, and no occupancy count is decremented below zero. The bench's worker stubs keep a queue for each worker of the numbers it accepted. They return the oldest entry of a chosen worker in a one-cycle pulse, so every response stays inside those assumptions. The order in which workers are drained is still chosen to force out-of-order completion.

// File: rtl/wdist_pkg.sv
package wdist_pkg;
    typedef enum logic {
        POL_ROUND_ROBIN = 1'b0,
        POL_LEAST_BUSY  = 1'b1
    } policy_e;
endpackage

// File: rtl/wdist_select.sv
module wdist_select #(
    parameter int NUM_WK = 4,
    parameter int OCC_W  = 5,
    parameter int IDX_W  = 2
) (
    input  logic                           policy_i,
    input  logic [IDX_W-1:0]               rr_ptr_i,
    input  logic [NUM_WK-1:0][OCC_W-1:0]   occ_i,
    output logic [IDX_W-1:0]               sel_o
);
    import wdist_pkg::*;

    logic [IDX_W-1:0] best_idx;
    logic [OCC_W-1:0] best_occ;

    // strict less-than keeps the lowest index on ties
    always_comb begin
        best_idx = '0;
        best_occ = occ_i[0];
        for (int i = 1; i < NUM_WK; i++) begin
            if (occ_i[i] < best_occ) begin
                best_occ = occ_i[i];
                best_idx = IDX_W'(i);
            end
        end
        sel_o = (policy_e'(policy_i) == POL_LEAST_BUSY) ? best_idx : rr_ptr_i;
    end
endmodule

// File: rtl/wdist_occupancy.sv
module wdist_occupancy #(
    parameter int NUM_WK = 4,
    parameter int OCC_W  = 5,
    parameter int IDX_W  = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           policy_i,
    input  logic                           disp_fire_i,
    input  logic [IDX_W-1:0]               disp_sel_i,
    input  logic [NUM_WK-1:0]              rsp_valid_i,
    output logic [NUM_WK-1:0][OCC_W-1:0]   occ_o,
    output logic [IDX_W-1:0]               rr_ptr_o
);
    import wdist_pkg::*;

    typedef struct packed {
        logic [NUM_WK-1:0][OCC_W-1:0] occ;
        logic [IDX_W-1:0]             ptr;
    } occ_state_t;

    occ_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_WK; i++) begin
            case ({disp_fire_i && (disp_sel_i == IDX_W'(i)), rsp_valid_i[i]})
                2'b10:   st_d.occ[i] = st_q.occ[i] + OCC_W'(1);
                2'b01:   st_d.occ[i] = st_q.occ[i] - OCC_W'(1);
                default: st_d.occ[i] = st_q.occ[i];
            endcase
        end
        if (disp_fire_i && (policy_e'(policy_i) == POL_ROUND_ROBIN)) begin
            st_d.ptr = (st_q.ptr == IDX_W'(NUM_WK - 1)) ? '0 : st_q.ptr + IDX_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign occ_o    = st_q.occ;
    assign rr_ptr_o = st_q.ptr;

    // R9: least-busy dispatch leaves the round-robin pointer where it was
    p_lb_keeps_ptr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_fire_i && policy_i) |=> $stable(rr_ptr_o));

    for (genvar g = 0; g < NUM_WK; g++) begin : g_chk
        // R3: a worker can only return work it holds
        p_occ_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
            rsp_valid_i[g] |-> (st_q.occ[g] != '0));
    end
endmodule

// File: rtl/wdist_reorder.sv
module wdist_reorder #(
    parameter int NUM_WK = 4,
    parameter int ID_W   = 4,
    parameter int RES_W  = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          alloc_i,
    output logic                          room_o,
    output logic [ID_W-1:0]               tail_o,
    input  logic [NUM_WK-1:0]             rsp_valid_i,
    input  logic [NUM_WK-1:0][ID_W-1:0]   rsp_id_i,
    input  logic [NUM_WK-1:0][RES_W-1:0]  rsp_data_i,
    output logic                          out_valid_o,
    input  logic                          out_ready_i,
    output logic [ID_W-1:0]               out_id_o,
    output logic [RES_W-1:0]              out_data_o
);
    localparam int DEPTH = 1 << ID_W;
    localparam int CNT_W = ID_W + 1;

    typedef struct packed {
        logic [DEPTH-1:0]            vld;
        logic [DEPTH-1:0][RES_W-1:0] dat;
        logic [ID_W-1:0]             head;
        logic [ID_W-1:0]             tail;
        logic [CNT_W-1:0]            cnt;
    } rob_state_t;

    rob_state_t st_d, st_q;
    logic       pop;

    always_comb begin
        st_d = st_q;
        pop  = st_q.vld[st_q.head] && out_ready_i;
        for (int i = 0; i < NUM_WK; i++) begin
            if (rsp_valid_i[i]) begin
                st_d.vld[rsp_id_i[i]] = 1'b1;
                st_d.dat[rsp_id_i[i]] = rsp_data_i[i];
            end
        end
        if (pop) begin
            st_d.vld[st_q.head] = 1'b0;
            st_d.head           = st_q.head + ID_W'(1);
        end
        if (alloc_i) st_d.tail = st_q.tail + ID_W'(1);
        case ({alloc_i, pop})
            2'b10:   st_d.cnt = st_q.cnt + CNT_W'(1);
            2'b01:   st_d.cnt = st_q.cnt - CNT_W'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign room_o      = st_q.cnt < CNT_W'(DEPTH);
    assign tail_o      = st_q.tail;
    assign out_valid_o = st_q.vld[st_q.head];
    assign out_id_o    = st_q.head;
    assign out_data_o  = st_q.dat[st_q.head];

    // R6: never more commands held than slots
    p_rob_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH));
    p_alloc_room_r6: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_i |-> room_o);
    // R8: the offered result holds under back-pressure
    p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i) |=>
            (out_valid_o && $stable(out_id_o) && $stable(out_data_o)));

    for (genvar g = 0; g < NUM_WK; g++) begin : g_chk
        // R5: a returning result lands in an empty slot
        p_slot_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
            rsp_valid_i[g] |-> !st_q.vld[rsp_id_i[g]]);
    end
endmodule

// File: rtl/work_distributor.sv
module work_distributor #(
    parameter int NUM_WK = 4,
    parameter int ID_W   = 4,
    parameter int DATA_W = 16,
    parameter int RES_W  = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      policy_sel,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic [DATA_W-1:0]         in_data,
    output logic [NUM_WK-1:0]         wk_req_valid,
    input  logic [NUM_WK-1:0]         wk_req_ready,
    output logic [NUM_WK*DATA_W-1:0]  wk_req_data,
    output logic [NUM_WK*ID_W-1:0]    wk_req_id,
    input  logic [NUM_WK-1:0]         wk_rsp_valid,
    output logic [NUM_WK-1:0]         wk_rsp_ready,
    input  logic [NUM_WK*RES_W-1:0]   wk_rsp_data,
    input  logic [NUM_WK*ID_W-1:0]    wk_rsp_id,
    output logic                      out_valid,
    input  logic                      out_ready,
    output logic [ID_W-1:0]           out_id,
    output logic [RES_W-1:0]          out_data
);
    localparam int IDX_W = (NUM_WK > 1) ? $clog2(NUM_WK) : 1;
    localparam int OCC_W = ID_W + 1;

    logic [IDX_W-1:0]              sel;
    logic [IDX_W-1:0]              rr_ptr;
    logic [NUM_WK-1:0][OCC_W-1:0]  occ;
    logic                          room;
    logic [ID_W-1:0]               tail;
    logic                          fire;
    logic [NUM_WK-1:0][ID_W-1:0]   rsp_id_a;
    logic [NUM_WK-1:0][RES_W-1:0]  rsp_dat_a;

    assign in_ready     = room && wk_req_ready[sel];
    assign fire         = in_valid && in_ready;
    assign wk_rsp_ready = '1;

    for (genvar g = 0; g < NUM_WK; g++) begin : g_port
        assign wk_req_valid[g]                  = in_valid && room && (sel == IDX_W'(g));
        assign wk_req_data[g*DATA_W +: DATA_W]  = in_data;
        assign wk_req_id[g*ID_W +: ID_W]        = tail;
        assign rsp_id_a[g]                      = wk_rsp_id[g*ID_W +: ID_W];
        assign rsp_dat_a[g]                     = wk_rsp_data[g*RES_W +: RES_W];
    end

    wdist_select #(.NUM_WK(NUM_WK), .OCC_W(OCC_W), .IDX_W(IDX_W)) u_select (
        .policy_i (policy_sel),
        .rr_ptr_i (rr_ptr),
        .occ_i    (occ),
        .sel_o    (sel)
    );

    wdist_occupancy #(.NUM_WK(NUM_WK), .OCC_W(OCC_W), .IDX_W(IDX_W)) u_occ (
        .clk         (clk),
        .rst_n       (rst_n),
        .policy_i    (policy_sel),
        .disp_fire_i (fire),
        .disp_sel_i  (sel),
        .rsp_valid_i (wk_rsp_valid),
        .occ_o       (occ),
        .rr_ptr_o    (rr_ptr)
    );

    wdist_reorder #(.NUM_WK(NUM_WK), .ID_W(ID_W), .RES_W(RES_W)) u_rob (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc_i     (fire),
        .room_o      (room),
        .tail_o      (tail),
        .rsp_valid_i (wk_rsp_valid),
        .rsp_id_i    (rsp_id_a),
        .rsp_data_i  (rsp_dat_a),
        .out_valid_o (out_valid),
        .out_ready_i (out_ready),
        .out_id_o    (out_id),
        .out_data_o  (out_data)
    );

    // R7: at most one worker sees a request at a time
    p_single_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wk_req_valid));

    for (genvar j = 0; j < NUM_WK; j++) begin : g_lb_chk
        // R3: the least-busy choice is no busier than any other worker
        p_lb_min_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (fire && policy_sel) |-> (occ[sel] <= occ[j]));
    end
endmodule

// File: tb/sim_work_distributor.sv
`timescale 1ns/1ps
module sim_work_distributor;
    localparam int NW   = 4;
    localparam int IW   = 4;
    localparam int DW   = 16;
    localparam logic [15:0] MASK = 16'h5A3C;

    // entry: {policy, worker to answer first (7 = none), expected worker}
    localparam logic [5:0] TBL [12] = '{
        {1'b0, 3'd7, 2'd0}, {1'b0, 3'd7, 2'd1}, {1'b0, 3'd7, 2'd2}, {1'b0, 3'd7, 2'd3},
        {1'b0, 3'd7, 2'd0}, {1'b1, 3'd7, 2'd1}, {1'b1, 3'd7, 2'd2}, {1'b1, 3'd7, 2'd3},
        {1'b1, 3'd2, 2'd2}, {1'b1, 3'd0, 2'd0}, {1'b0, 3'd7, 2'd1}, {1'b1, 3'd3, 2'd3}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              policy_sel = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [DW-1:0]     in_data = '0;
    logic [NW-1:0]     wk_req_valid;
    logic [NW-1:0]     wk_req_ready = '1;
    logic [NW*DW-1:0]  wk_req_data;
    logic [NW*IW-1:0]  wk_req_id;
    logic [NW-1:0]     wk_rsp_valid = '0;
    logic [NW-1:0]     wk_rsp_ready;
    logic [NW*DW-1:0]  wk_rsp_data = '0;
    logic [NW*IW-1:0]  wk_rsp_id = '0;
    logic              out_valid;
    logic              out_ready = 1'b1;
    logic [IW-1:0]     out_id;
    logic [DW-1:0]     out_data;

    int checks = 0, errors = 0, mchecks = 0, merr = 0;
    int next_id = 0, mon_expect = 0, mon_count = 0;
    logic [15:0] exp_res [16];
    int          wq_id  [NW][64];
    logic [15:0] wq_dat [NW][64];
    int          wq_wr  [NW];
    int          wq_rd  [NW];

    always #10 clk = ~clk;

    work_distributor u0 (
        .clk(clk), .rst_n(rst_n), .policy_sel(policy_sel),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .wk_req_valid(wk_req_valid), .wk_req_ready(wk_req_ready),
        .wk_req_data(wk_req_data), .wk_req_id(wk_req_id),
        .wk_rsp_valid(wk_rsp_valid), .wk_rsp_ready(wk_rsp_ready),
        .wk_rsp_data(wk_rsp_data), .wk_rsp_id(wk_rsp_id),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_id(out_id), .out_data(out_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // ordered-output monitor (R5)
    always @(negedge clk) begin
        #2;
        if (rst_n && out_valid && out_ready) begin
            mchecks++;
            if (out_id != IW'(mon_expect) || out_data != exp_res[out_id]) begin
                merr++;
                $display("FAIL R5 actual id=%0d data=%0h expected id=%0d data=%0h",
                         out_id, out_data, mon_expect, exp_res[IW'(mon_expect)]);
            end
            mon_expect = (mon_expect + 1) % 16;
            mon_count++;
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        wk_rsp_valid = '0;
        out_ready = 1'b1;
        wk_req_ready = '1;
        for (int i = 0; i < NW; i++) begin wq_wr[i] = 0; wq_rd[i] = 0; end
        next_id = 0; mon_expect = 0; mon_count = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        check(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
        check(wk_req_valid == '0, "R1 req_valid", int'(wk_req_valid), 0);
        check(wk_rsp_ready == '1, "R1 rsp_ready", int'(wk_rsp_ready), 15);
    endtask

    task automatic send(input logic pol, input logic [15:0] d, input int exp_w, input string tag);
        int w;
        int id;
        @(negedge clk);
        policy_sel = pol; in_valid = 1'b1; in_data = d;
        #1;
        while (!in_ready) begin @(negedge clk); #1; end
        w = -1;
        for (int i = 0; i < NW; i++) if (wk_req_valid[i]) w = i;
        check(w == exp_w, tag, w, exp_w);
        if (w >= 0) begin
            id = int'(wk_req_id[w*IW +: IW]);
            check(id == next_id, "R4 sequence id", id, next_id);
            wq_id[w][wq_wr[w]]  = id;
            wq_dat[w][wq_wr[w]] = d ^ MASK;
            wq_wr[w]++;
            exp_res[id] = d ^ MASK;
        end
        next_id = (next_id + 1) % 16;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic respond(input int w);
        @(negedge clk);
        wk_rsp_valid = '0;
        wk_rsp_valid[w] = 1'b1;
        wk_rsp_id[w*IW +: IW]   = IW'(wq_id[w][wq_rd[w]]);
        wk_rsp_data[w*DW +: DW] = wq_dat[w][wq_rd[w]];
        wq_rd[w]++;
        @(negedge clk);
        wk_rsp_valid = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks + mchecks, errors + merr);
        $finish;
    end

    initial begin
        logic [15:0] held;
        do_reset();

        // table walk: R2 round-robin, R3 least-busy, R9 pointer kept across policies
        for (int k = 0; k < 12; k++) begin
            if (TBL[k][4:2] != 3'd7) respond(int'(TBL[k][4:2]));
            send(TBL[k][5], 16'h1000 + 16'(k), int'(TBL[k][1:0]),
                 TBL[k][5] ? "R3 least-busy worker" : ((k == 10) ? "R9 pointer resumes" : "R2 round-robin worker"));
        end

        // R8: back-pressure holds the head result
        @(negedge clk); out_ready = 1'b0;
        respond(1);
        repeat (2) @(negedge clk);
        #1;
        check(out_valid == 1'b1, "R8 out_valid", int'(out_valid), 1);
        check(out_id == 4'd1, "R8 out_id", int'(out_id), 1);
        held = out_data;
        repeat (2) @(negedge clk);
        #1;
        check(out_valid == 1'b1 && out_id == 4'd1 && out_data == held, "R8 hold",
              int'(out_data), int'(held));
        check(out_data == exp_res[1], "R8 data", int'(out_data), int'(exp_res[1]));
        @(negedge clk); out_ready = 1'b1;

        // R5: drain workers in reverse order, results must still come out in order
        for (int w = NW - 1; w >= 0; w--)
            while (wq_rd[w] < wq_wr[w]) respond(w);
        repeat (10) @(negedge clk);
        #1;
        check(mon_count == 12, "R5 all released", mon_count, 12);
        check(out_valid == 1'b0, "R5 empty", int'(out_valid), 0);

        // R6: fill all 16 slots
        for (int k = 0; k < 16; k++)
            send(1'b0, 16'h2000 + 16'(k), (2 + k) % 4, "R2 fill round-robin");
        @(negedge clk); in_valid = 1'b1;
        #1;
        check(in_ready == 1'b0, "R6 full stall", int'(in_ready), 0);
        check(wk_req_valid == '0, "R6 no request when full", int'(wk_req_valid), 0);
        @(negedge clk); in_valid = 1'b0;
        respond(3);
        repeat (3) @(negedge clk);
        #1;
        check(out_valid == 1'b0, "R5 head missing", int'(out_valid), 0);
        check(in_ready == 1'b0, "R6 still full", int'(in_ready), 0);
        respond(2);
        repeat (3) @(negedge clk);
        #1;
        check(in_ready == 1'b1, "R6 slot freed", int'(in_ready), 1);
        check(mon_count == 14, "R5 released count", mon_count, 14);

        // R7: selected worker not ready
        @(negedge clk);
        wk_req_ready = 4'b1011; policy_sel = 1'b0; in_valid = 1'b1;
        #1;
        check(in_ready == 1'b0, "R7 stall", int'(in_ready), 0);
        check(wk_req_valid == 4'b0100, "R7 only selected", int'(wk_req_valid), 4);
        repeat (3) @(negedge clk);
        #1;
        check(in_ready == 1'b0, "R7 still stalled", int'(in_ready), 0);
        in_valid = 1'b0;
        wk_req_ready = '1;
        send(1'b0, 16'h3000, 2, "R7 same worker after stall");

        // R1: reset mid-run clears pointer, counts and slots
        do_reset();
        send(1'b1, 16'h4000, 0, "R1 least-busy after reset");
        send(1'b0, 16'h4001, 0, "R1 pointer cleared");
        send(1'b1, 16'h4002, 1, "R3 after reset");

        $display("CHECKS %0d ERRORS %0d", checks + mchecks, errors + merr);
        $finish;
    end
endmodule